// File: doc/BRIEF.md
# Scan Instruction Register and Decoder

This block holds the instruction of a boundary-scan test port. An eight-bit serial stage sits between the test data input and a serial output, and a parallel shadow stage sits behind it. The shadow stage holds the active instruction. Strobes from an external test-port controller choose what happens on each cycle: reset to the default instruction, parallel capture, serial shift or update. The controller itself lies outside this block.

The shadow stage is decoded into three outputs. The first is a one-hot select of the data register to put in the scan path: the single-bit bypass register, the boundary register or a control register. The second is a flag that marks test mode, in which the normal function is inhibited. The third chooses the source from which the selected data register captures. The bypass flip-flop is included in the block because it serves the default instruction. The serial stage updates on the rising edge of the test clock. The shadow stage updates on the falling edge, so the decoded outputs do not move while bits are being shifted.

Top module: `scan_ir_ctrl`

## Requirements
- R1: While rst_ni is low, the serial stage and the shadow stage both hold all ones and the bypass flip-flop holds 0. The decode outputs are dr_sel_o=3'b001 (bypass), test_mode_o=0 and cap_src_o=0.
- R2: A rising edge with cap_ir_i high loads 8'b10000001 into the serial stage. Over eight shift cycles that follow, ir_so_o presents it LSB first.
- R3: A rising edge with shift_ir_i high (and cap_ir_i low) moves tdi_i into bit 7 and each bit one place toward bit 0. ir_so_o always equals bit 0. With neither strobe high, the serial stage holds its value.
- R4: The shadow stage loads the serial stage only on a falling edge with upd_ir_i high. Capture and shift cycles leave the decode outputs unchanged.
- R5: A falling edge with tlr_i high sets the shadow stage to all ones, which decodes as bypass. This takes priority over upd_ir_i.
- R6: Bit 7 of the instruction does not affect decoding. Opcodes 8'h80 and 8'h00 decode the same way, and so do 8'h82 and 8'h02.
- R7: Decoding works on the low seven bits. 7'h00 gives boundary (dr_sel_o=3'b010), test_mode_o=1 and cap_src_o=1 (pins). 7'h02 gives boundary, test_mode_o=0 and cap_src_o=1. 7'h0A gives control (3'b100), test_mode_o=0 and cap_src_o=2 (hold). 7'h7F gives bypass (3'b001), test_mode_o=0 and cap_src_o=0 (zero).
- R8: Every other opcode decodes as bypass. No parity check is applied, so 8'h01 and 8'h55 both give bypass.
- R9: When bypass is selected, a rising edge with cap_dr_i loads 0 into the bypass flip-flop and a rising edge with shift_dr_i loads tdi_i. When bypass is not selected, the flip-flop holds its value. byp_so_o shows the flip-flop.
- R10: dr_sel_o has exactly one bit set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tlr_i | input | 1 | Controller is in test-logic-reset |
| cap_ir_i | input | 1 | Controller is in capture-IR |
| shift_ir_i | input | 1 | Controller is in shift-IR |
| upd_ir_i | input | 1 | Controller is in update-IR |
| cap_dr_i | input | 1 | Controller is in capture-DR |
| shift_dr_i | input | 1 | Controller is in shift-DR |
| tdi_i | input | 1 | Serial test data in |
| ir_so_o | output | 1 | Instruction path serial out |
| byp_so_o | output | 1 | Bypass register serial out |
| dr_sel_o | output | 3 | One-hot data register select: bit0 bypass, bit1 boundary, bit2 control |
| test_mode_o | output | 1 | Normal function inhibited |
| cap_src_o | output | 2 | Capture source: 0 zero, 1 pins, 2 hold |

## Verification
Each opcode is loaded with a full capture, shift and update sequence. This shows that the captured byte comes out LSB first, whatever opcode is being shifted in behind it. The opcodes tried are every supported code, the same codes with bit 7 set, and codes that are either unsupported or of odd parity. Together they separate true decoding from decoding on all eight bits, from a parity check and from a fallback to some value other than bypass. An instruction is also shifted in without an update, and test-logic-reset is raised together with update. These two cases separate updates on the shadow stage from the serial stage leaking into the decode. Bypass data scans are run both with bypass selected and with it not selected.

// File: rtl/scan_ir_pkg.sv
package scan_ir_pkg;
  localparam int unsigned NUM_DR  = 3;
  localparam int unsigned SEL_BYP = 0;
  localparam int unsigned SEL_BND = 1;
  localparam int unsigned SEL_CTL = 2;

  typedef enum logic [1:0] {
    CAP_ZERO = 2'd0,
    CAP_PINS = 2'd1,
    CAP_HOLD = 2'd2
  } cap_src_e;

  typedef struct packed {
    logic [NUM_DR-1:0] dr_sel;
    logic              test_mode;
    cap_src_e          cap_src;
  } ir_dec_t;
endpackage

// File: rtl/scan_ir_shift.sv
module scan_ir_shift #(
  parameter int unsigned     IR_W    = 8,
  parameter logic [IR_W-1:0] CAP_PAT = 8'b1000_0001,
  parameter logic [IR_W-1:0] RST_PAT = '1
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            shift_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] sr_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      sr_o <= RST_PAT;
    else if (cap_i)   sr_o <= CAP_PAT;
    else if (shift_i) sr_o <= {tdi_i, sr_o[IR_W-1:1]};
  end

  AST_CAP_LOAD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cap_i |=> sr_o == CAP_PAT); // R2
  AST_SHIFT_MOVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !cap_i) |=> (sr_o[IR_W-1] == $past(tdi_i)) &&
                            (sr_o[IR_W-2:0] == $past(sr_o[IR_W-1:1]))); // R3
  AST_SR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_i && !cap_i) |=> $stable(sr_o)); // R3
endmodule

// File: rtl/scan_ir_shadow.sv
module scan_ir_shadow #(
  parameter int unsigned     IR_W    = 8,
  parameter logic [IR_W-1:0] RST_PAT = '1
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            upd_i,
  input  logic [IR_W-1:0] d_i,
  output logic [IR_W-1:0] q_o
);
  // falling edge: decode settles half a cycle before the next shift edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_PAT;
    else if (tlr_i) q_o <= RST_PAT;
    else if (upd_i) q_o <= d_i;
  end

  AST_TLR_DEFAULT: assert property (@(negedge tck_i) disable iff (!rst_ni)
    tlr_i |=> q_o == RST_PAT); // R5
  AST_UPD_LOAD: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (upd_i && !tlr_i) |=> q_o == $past(d_i)); // R4
  AST_SHADOW_HOLD: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!upd_i && !tlr_i) |=> $stable(q_o)); // R4
endmodule

// File: rtl/scan_ir_decode.sv
module scan_ir_decode
  import scan_ir_pkg::*;
#(
  parameter int unsigned     IR_W       = 8,
  parameter logic [IR_W-2:0] OPC_EXTEST = 7'h00,
  parameter logic [IR_W-2:0] OPC_SAMPLE = 7'h02,
  parameter logic [IR_W-2:0] OPC_CTRL   = 7'h0A,
  parameter logic [IR_W-2:0] OPC_BYPASS = 7'h7F
) (
  input  logic [IR_W-1:0] ir_i,
  output ir_dec_t         dec_o
);
  logic [IR_W-2:0] opc;
  assign opc = ir_i[IR_W-2:0]; // top bit is don't-care

  always_comb begin
    dec_o.dr_sel    = '0;
    dec_o.test_mode = 1'b0;
    dec_o.cap_src   = CAP_ZERO;
    if (opc == OPC_EXTEST) begin
      dec_o.dr_sel[SEL_BND] = 1'b1;
      dec_o.test_mode       = 1'b1;
      dec_o.cap_src         = CAP_PINS;
    end else if (opc == OPC_SAMPLE) begin
      dec_o.dr_sel[SEL_BND] = 1'b1;
      dec_o.cap_src         = CAP_PINS;
    end else if (opc == OPC_CTRL) begin
      dec_o.dr_sel[SEL_CTL] = 1'b1;
      dec_o.cap_src         = CAP_HOLD;
    end else if (opc == OPC_BYPASS) begin
      dec_o.dr_sel[SEL_BYP] = 1'b1;
    end else begin
      dec_o.dr_sel[SEL_BYP] = 1'b1; // unsupported falls back to bypass
    end
  end
endmodule

// File: rtl/scan_bypass_cell.sv
module scan_bypass_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cap_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic q_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 q_o <= 1'b0;
    else if (en_i && cap_i)      q_o <= 1'b0;
    else if (en_i && shift_i)    q_o <= tdi_i;
  end

  AST_BYP_CAP_ZERO: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (en_i && cap_i) |=> !q_o); // R9
  AST_BYP_IDLE_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R9
endmodule

// File: rtl/scan_ir_ctrl.sv
module scan_ir_ctrl
  import scan_ir_pkg::*;
#(
  parameter int unsigned     IR_W       = 8,
  parameter logic [IR_W-1:0] CAP_PAT    = 8'b1000_0001,
  parameter logic [IR_W-1:0] RST_PAT    = '1,
  parameter logic [IR_W-2:0] OPC_EXTEST = 7'h00,
  parameter logic [IR_W-2:0] OPC_SAMPLE = 7'h02,
  parameter logic [IR_W-2:0] OPC_CTRL   = 7'h0A,
  parameter logic [IR_W-2:0] OPC_BYPASS = 7'h7F
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic              cap_ir_i,
  input  logic              shift_ir_i,
  input  logic              upd_ir_i,
  input  logic              cap_dr_i,
  input  logic              shift_dr_i,
  input  logic              tdi_i,
  output logic              ir_so_o,
  output logic              byp_so_o,
  output logic [NUM_DR-1:0] dr_sel_o,
  output logic              test_mode_o,
  output logic [1:0]        cap_src_o
);
  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] shadow_q;
  ir_dec_t         dec;

  scan_ir_shift #(.IR_W(IR_W), .CAP_PAT(CAP_PAT), .RST_PAT(RST_PAT)) u_shift (
    .tck_i(tck_i), .rst_ni(rst_ni), .cap_i(cap_ir_i), .shift_i(shift_ir_i),
    .tdi_i(tdi_i), .sr_o(sr_q)
  );

  scan_ir_shadow #(.IR_W(IR_W), .RST_PAT(RST_PAT)) u_shadow (
    .tck_i(tck_i), .rst_ni(rst_ni), .tlr_i(tlr_i), .upd_i(upd_ir_i),
    .d_i(sr_q), .q_o(shadow_q)
  );

  scan_ir_decode #(
    .IR_W(IR_W), .OPC_EXTEST(OPC_EXTEST), .OPC_SAMPLE(OPC_SAMPLE),
    .OPC_CTRL(OPC_CTRL), .OPC_BYPASS(OPC_BYPASS)
  ) u_dec (
    .ir_i(shadow_q), .dec_o(dec)
  );

  scan_bypass_cell u_byp (
    .tck_i(tck_i), .rst_ni(rst_ni), .en_i(dec.dr_sel[SEL_BYP]),
    .cap_i(cap_dr_i), .shift_i(shift_dr_i), .tdi_i(tdi_i), .q_o(byp_so_o)
  );

  assign ir_so_o     = sr_q[0];
  assign dr_sel_o    = dec.dr_sel;
  assign test_mode_o = dec.test_mode;
  assign cap_src_o   = dec.cap_src;

  AST_SEL_ONE_HOT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones(dr_sel_o) == 1); // R10
  AST_DECODE_STILL_AT_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!upd_ir_i && !tlr_i) |-> $stable(test_mode_o) || $rose(rst_ni)); // R4
endmodule

// File: tb/tb_scan_ir_ctrl.sv
module tb_scan_ir_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic tlr, cir, sir, uir, cdr, sdr, tdi;
  logic ir_so, byp_so, test_mode;
  logic [2:0] dr_sel;
  logic [1:0] cap_src;

  int vec = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_sr, m_sh;
  logic       m_byp;
  logic       last_so;

  always #4 clk = ~clk;

  scan_ir_ctrl dut (
    .tck_i(clk), .rst_ni(rst_n), .tlr_i(tlr), .cap_ir_i(cir), .shift_ir_i(sir),
    .upd_ir_i(uir), .cap_dr_i(cdr), .shift_dr_i(sdr), .tdi_i(tdi),
    .ir_so_o(ir_so), .byp_so_o(byp_so), .dr_sel_o(dr_sel),
    .test_mode_o(test_mode), .cap_src_o(cap_src)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mdec(input logic [7:0] v, output logic [2:0] sel,
                      output logic mode, output logic [1:0] src);
    logic [6:0] o;
    o = v[6:0];
    if (o == 7'h00)      begin sel = 3'b010; mode = 1'b1; src = 2'd1; end
    else if (o == 7'h02) begin sel = 3'b010; mode = 1'b0; src = 2'd1; end
    else if (o == 7'h0A) begin sel = 3'b100; mode = 1'b0; src = 2'd2; end
    else                 begin sel = 3'b001; mode = 1'b0; src = 2'd0; end
  endtask

  // one TCK cycle: drive at +2, falling edge acts at +4, compare at +6
  task automatic step(input logic t, input logic ci, input logic si, input logic ui,
                      input logic cd, input logic sd, input logic d);
    logic [2:0] sel;
    logic mode;
    logic [1:0] src;
    @(posedge clk);
    #2;
    tlr = t; cir = ci; sir = si; uir = ui; cdr = cd; sdr = sd; tdi = d;
    #4;
    if (t) m_sh = 8'hFF;
    else if (ui) m_sh = m_sr;
    mdec(m_sh, sel, mode, src);
    chk("R7 dr_sel", dr_sel, sel);
    chk("R4 test_mode", test_mode, mode);
    chk("R7 cap_src", cap_src, src);
    chk("R3 ir_so", ir_so, m_sr[0]);
    chk("R9 byp_so", byp_so, m_byp);
    chk("R10 one-hot", $countones(dr_sel), 1);
    last_so = ir_so;
    if (ci) m_sr = 8'h81;
    else if (si) m_sr = {d, m_sr[7:1]};
    if (sel[0]) begin
      if (cd) m_byp = 1'b0;
      else if (sd) m_byp = d;
    end
  endtask

  task automatic load_ir(input logic [7:0] op, input bit do_upd);
    logic [7:0] seen;
    step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 1, 0, 0, 0, op[i]);
      seen[i] = last_so;
    end
    chk("R2 captured byte out", seen, 8'h81);
    step(0, 0, 0, 0, 0, 0, 0);
    if (do_upd) step(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {tlr, cir, sir, uir, cdr, sdr, tdi} = '0;
    @(posedge clk); #6;
    chk("R1 reset dr_sel", dr_sel, 3'b001);
    chk("R1 reset test_mode", test_mode, 1'b0);
    chk("R1 reset cap_src", cap_src, 2'd0);
    chk("R1 reset ir_so", ir_so, 1'b1);
    chk("R1 reset byp_so", byp_so, 1'b0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    m_sr = 8'hFF; m_sh = 8'hFF; m_byp = 1'b0;

    // R9: bypass scan with default instruction
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9 bypass shifted tdi", byp_so, 1'b1);

    // R7 supported set
    load_ir(8'h00, 1);
    chk("R7 extest mode", test_mode, 1'b1);
    chk("R7 extest sel", dr_sel, 3'b010);
    // R9: bypass not selected holds
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9 bypass held when unselected", byp_so, 1'b1);
    // R4: shift new opcode without update, decode unchanged
    load_ir(8'h7F, 0);
    chk("R4 no update keeps extest", test_mode, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R4 update applies bypass", dr_sel, 3'b001);

    load_ir(8'h02, 1);
    chk("R7 sample sel", dr_sel, 3'b010);
    chk("R7 sample mode", test_mode, 1'b0);
    load_ir(8'h0A, 1);
    chk("R7 ctrl sel", dr_sel, 3'b100);
    chk("R7 ctrl src", cap_src, 2'd2);

    // R6 bit 7 ignored
    load_ir(8'h80, 1);
    chk("R6 80 as extest", {dr_sel, test_mode}, {3'b010, 1'b1});
    load_ir(8'h82, 1);
    chk("R6 82 as sample", {dr_sel, test_mode, cap_src}, {3'b010, 1'b0, 2'd1});
    load_ir(8'h8A, 1);
    chk("R6 8A as ctrl", dr_sel, 3'b100);

    // R8 unsupported and parity-free
    load_ir(8'h55, 1);
    chk("R8 55 bypass", dr_sel, 3'b001);
    load_ir(8'h00, 1);
    load_ir(8'h01, 1);
    chk("R8 01 bypass", {dr_sel, test_mode}, {3'b001, 1'b0});
    load_ir(8'hFF, 1);
    chk("R8 FF bypass", dr_sel, 3'b001);

    // R5 tlr beats update
    load_ir(8'h00, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    chk("R5 tlr over update", {dr_sel, test_mode}, {3'b001, 1'b0});
    load_ir(8'h02, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R5 tlr to bypass", dr_sel, 3'b001);
    step(0, 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule